// File: doc/BRIEF.md
# Multichannel ADC Conversion Sequencer

This block sits between a simple register bus and a shared auxiliary converter that serves sixteen analog inputs. Software picks a channel and starts a conversion by dropping that channel's command bit and raising it again. The rising bit starts one conversion. A status flag reads busy for the whole conversion. When the conversion ends, the block stores a 12-bit result and a ready flag in that channel's data word.

Only one conversion runs at a time. A start request that arrives while the converter is busy is dropped, and software is expected to poll the busy flag before it issues a new command. The converter itself is a stub: after `CONV_CYCLES` clock cycles it returns a value computed from the channel number. The default latency of 2500 cycles matches a 25 µs read window at a 100 MHz clock.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The register map is as follows:
  - Address 0 holds the command word. Bit N belongs to channel N. Bits at positions N_CH and above read 0, and writes to them have no effect.
  - Address 1 is status. Bit 0 is busy, and all other bits read 0.
  - Address 2**CH_W + N is the data word of channel N. It is read-only, and writes to it have no effect.
  - Every other address reads 0.
- R2: A command write that turns a channel's bit from 0 to 1 while the block is idle starts a conversion. Busy reads 1 in the cycle after the write edge.
- R3: Busy stays high for exactly CONV_CYCLES cycles. It drops on the same edge that writes the result.
- R4: A finished conversion on channel c sets the data word to the result in bits 11:0 and a ready flag of 1 in bit 12, with all higher bits 0. The result is (c*SAMPLE_MUL + SAMPLE_OFF) mod 4096.
- R5: A command write that turns a channel's bit from 1 to 0 clears that channel's ready flag (bit 12) and keeps its bits 11:0. If the clear falls on the edge where that same channel completes, the completion takes effect.
- R6: A rising command bit that arrives while busy is high is ignored. It is not queued, and no conversion follows for it.
- R7: If one idle write raises several bits, only the lowest-numbered channel converts. The other rising bits are ignored.
- R8: A conversion leaves the data words of all other channels unchanged.
- R9: Reset clears every command bit, every ready flag, busy, and all result data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, combinational from addr_i |

## Verification
The bench builds the block with sixteen channels and CONV_CYCLES set to 8. The result formula uses SAMPLE_MUL = 257 and SAMPLE_OFF = 171, so each channel returns a distinct and easily recognised value. The short latency lets the bench count the busy window to the exact edge and inject a second start in the middle of a conversion. The full channel count means the highest channel and the command bits above the channel range are both exercised.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned REG_CMD  = 0;
  localparam int unsigned REG_STAT = 1;

  typedef enum logic {
    CONV_IDLE,
    CONV_RUN
  } conv_st_e;
endpackage

// File: rtl/adc_cmd_reg.sv
module adc_cmd_reg #(
  parameter int N_CH = 16,
  parameter int DW   = 32,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [N_CH-1:0] cmd_o,
  output logic            start_o,
  output logic [CH_W-1:0] start_ch_o,
  output logic [N_CH-1:0] fall_o
);
  logic [N_CH-1:0] cmd_q, nxt, rise;

  assign nxt    = wdata_i[N_CH-1:0];
  assign rise   = wr_i ? (nxt & ~cmd_q) : '0;
  assign fall_o = wr_i ? (~nxt & cmd_q) : '0;
  assign start_o = |rise;
  assign cmd_o  = cmd_q;

  // lowest rising index wins
  always_comb begin
    start_ch_o = '0;
    for (int i = N_CH - 1; i >= 0; i--)
      if (rise[i]) start_ch_o = CH_W'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   cmd_q <= '0;
    else if (wr_i) cmd_q <= nxt;
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_seq_pkg::*;
#(
  parameter int N_CH        = 16,
  parameter int RES_W       = 12,
  parameter int CONV_CYCLES = 2500,
  parameter int SAMPLE_MUL  = 257,
  parameter int SAMPLE_OFF  = 171,
  localparam int CH_W  = $clog2(N_CH),
  localparam int CNT_W = $clog2(CONV_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CH_W-1:0]  start_ch_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CH_W-1:0]  done_ch_o,
  output logic [RES_W-1:0] sample_o
);
  conv_st_e   st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CH_W-1:0]  ch_q;
  logic [31:0]      prod;

  assign busy_o    = (st_q == CONV_RUN);
  assign done_o    = busy_o && (cnt_q == '0);
  assign done_ch_o = ch_q;

  // converter stub: deterministic per-channel value
  assign prod     = 32'(ch_q) * 32'(SAMPLE_MUL) + 32'(SAMPLE_OFF);
  assign sample_o = prod[RES_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q  <= CONV_IDLE;
      cnt_q <= '0;
      ch_q  <= '0;
    end else begin
      case (st_q)
        CONV_IDLE:
          if (start_i) begin
            st_q  <= CONV_RUN;
            cnt_q <= CNT_W'(CONV_CYCLES - 1);
            ch_q  <= start_ch_i;
          end
        default:
          if (cnt_q == '0) st_q <= CONV_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
      endcase
    end
endmodule

// File: rtl/adc_data_bank.sv
module adc_data_bank #(
  parameter int N_CH  = 16,
  parameter int RES_W = 12,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic [CH_W-1:0]  done_ch_i,
  input  logic [RES_W-1:0] sample_i,
  input  logic [N_CH-1:0]  clr_i,
  output logic [RES_W-1:0] res_o [N_CH],
  output logic [N_CH-1:0]  rdy_o
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic hit;
    assign hit = done_i && (done_ch_i == CH_W'(g));

    // completion takes effect over a same-edge clear
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) begin
        res_o[g] <= '0;
        rdy_o[g] <= 1'b0;
      end else if (hit) begin
        res_o[g] <= sample_i;
        rdy_o[g] <= 1'b1;
      end else if (clr_i[g]) begin
        rdy_o[g] <= 1'b0;
      end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int N_CH        = 16,
  parameter int RES_W       = 12,
  parameter int DW          = 32,
  parameter int CONV_CYCLES = 2500,
  parameter int SAMPLE_MUL  = 257,
  parameter int SAMPLE_OFF  = 171,
  localparam int CH_W   = $clog2(N_CH),
  localparam int ADDR_W = CH_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o
);
  logic              cmd_wr, start, busy, done;
  logic [N_CH-1:0]   cmd, fall, rdy_vec;
  logic [CH_W-1:0]   start_ch, done_ch, rd_idx;
  logic [RES_W-1:0]  sample;
  logic [RES_W-1:0]  res [N_CH];

  assign cmd_wr = we_i && (addr_i == ADDR_W'(REG_CMD));
  assign rd_idx = addr_i[CH_W-1:0];

  adc_cmd_reg #(.N_CH(N_CH), .DW(DW)) u_cmd (
    .clk_i, .rst_ni, .wr_i(cmd_wr), .wdata_i,
    .cmd_o(cmd), .start_o(start), .start_ch_o(start_ch), .fall_o(fall)
  );

  adc_conv_ctrl #(
    .N_CH(N_CH), .RES_W(RES_W), .CONV_CYCLES(CONV_CYCLES),
    .SAMPLE_MUL(SAMPLE_MUL), .SAMPLE_OFF(SAMPLE_OFF)
  ) u_conv (
    .clk_i, .rst_ni, .start_i(start), .start_ch_i(start_ch),
    .busy_o(busy), .done_o(done), .done_ch_o(done_ch), .sample_o(sample)
  );

  adc_data_bank #(.N_CH(N_CH), .RES_W(RES_W)) u_bank (
    .clk_i, .rst_ni, .done_i(done), .done_ch_i(done_ch), .sample_i(sample),
    .clr_i(fall), .res_o(res), .rdy_o(rdy_vec)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i[ADDR_W-1]) begin
      if (int'(rd_idx) < N_CH) begin
        rdata_o[RES_W-1:0] = res[rd_idx];
        rdata_o[RES_W]     = rdy_vec[rd_idx];
      end
    end else if (addr_i == ADDR_W'(REG_CMD)) begin
      rdata_o[N_CH-1:0] = cmd;
    end else if (addr_i == ADDR_W'(REG_STAT)) begin
      rdata_o[0] = busy;
    end
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int N_CH        = 16,
  parameter int DW          = 32,
  parameter int CONV_CYCLES = 2500
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cmd_wr_i,
  input logic [DW-1:0]   wdata_i,
  input logic [N_CH-1:0] cmd_i,
  input logic            busy_i,
  input logic [N_CH-1:0] rdy_i
);
  logic [31:0] busy_run;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     busy_run <= '0;
    else if (busy_i) busy_run <= busy_run + 1;
    else             busy_run <= '0;

  // R3
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> busy_run < 32'(CONV_CYCLES));

  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && !busy_i && |(wdata_i[N_CH-1:0] & ~cmd_i)) |=> busy_i);

  // R6
  busy_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(cmd_wr_i));

  // R4
  done_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> rdy_i != '0);

  // R5
  clr_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && !busy_i) |=> (rdy_i & $past(cmd_i & ~wdata_i[N_CH-1:0])) == '0);
endmodule

bind adc_seq_ctrl adc_seq_chk #(.N_CH(N_CH), .DW(DW), .CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_wr_i(cmd_wr), .wdata_i(wdata_i),
  .cmd_i(cmd), .busy_i(busy), .rdy_i(rdy_vec)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  localparam int N_CH = 16, DW = 32, CC = 8, AW = 5;
  localparam logic [AW-1:0] A_CMD = 0, A_STAT = 1;
  // {channel, expected result}
  localparam logic [15:0] VEC [5] = '{16'h00AB, 16'h33AE, 16'h77B2, 16'h99B4, 16'hFFBA};

  logic clk = 0, rst_n = 0, we = 0;
  logic [AW-1:0] addr = 0;
  logic [DW-1:0] wdata = 0, rdata, rv;
  logic [N_CH-1:0] shadow = 0;
  int errs = 0, chks = 0;
  bit fin = 0;

  always #5 clk = ~clk;

  adc_seq_ctrl #(.N_CH(N_CH), .DW(DW), .CONV_CYCLES(CC),
    .SAMPLE_MUL(257), .SAMPLE_OFF(171)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata));

  function automatic logic [AW-1:0] dadr(int c);
    return AW'(16 + c);
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    chks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    addr = a; wdata = d; we = 1;
    @(posedge clk); @(negedge clk);
    we = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      errs++; chks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end

  initial begin
    cyc(2); rst_n = 1; cyc(1);
    // R9 reset state
    rd(A_CMD, rv);   chk("R9 cmd", rv, 0);
    rd(A_STAT, rv);  chk("R9 busy", rv, 0);
    rd(dadr(0), rv); chk("R9 data0", rv, 0);

    // R2 R3 R4 R8 table walk
    for (int i = 0; i < 5; i++) begin
      int c;
      c = int'(VEC[i][15:12]);
      wr(A_CMD, DW'(shadow & ~(N_CH'(1) << c)));
      shadow |= N_CH'(1) << c;
      wr(A_CMD, DW'(shadow));
      rd(A_STAT, rv); chk("R2 busy after start", rv, 1);
      cyc(CC - 1);
      rd(A_STAT, rv); chk("R3 busy last cycle", rv, 1);
      rd(dadr(c), rv); chk("R3 not ready early", rv, 0);
      cyc(1);
      rd(A_STAT, rv); chk("R3 busy dropped", rv, 0);
      rd(dadr(c), rv); chk("R4 result", rv, DW'({1'b1, VEC[i][11:0]}));
      if (i > 0) begin
        rd(dadr(int'(VEC[i-1][15:12])), rv);
        chk("R8 prior kept", rv, DW'({1'b1, VEC[i-1][11:0]}));
      end
    end

    // R5 falling edge clears ready, keeps data
    shadow[0] = 1'b0;
    wr(A_CMD, DW'(shadow));
    rd(dadr(0), rv); chk("R5 ready cleared", rv, 32'h0AB);
    rd(dadr(3), rv); chk("R8 ch3 kept", rv, 32'h13AE);

    // R6 start during busy ignored
    shadow[1] = 1'b1;
    wr(A_CMD, DW'(shadow));
    cyc(2);
    shadow[2] = 1'b1;
    wr(A_CMD, DW'(shadow));
    cyc(CC);
    rd(A_STAT, rv); chk("R6 idle after", rv, 0);
    cyc(1);
    rd(A_STAT, rv); chk("R6 not queued", rv, 0);
    rd(dadr(2), rv); chk("R6 ch2 untouched", rv, 0);
    rd(dadr(1), rv); chk("R4 ch1", rv, 32'h11AC);

    // R7 multiple rising bits: lowest wins
    shadow[5:4] = 2'b11;
    wr(A_CMD, DW'(shadow));
    cyc(CC);
    rd(A_STAT, rv); chk("R7 idle", rv, 0);
    rd(dadr(4), rv); chk("R7 ch4 converted", rv, 32'h14AF);
    rd(dadr(5), rv); chk("R7 ch5 ignored", rv, 0);

    // R1 map
    wr(A_CMD, 32'hFFFF_0000 | DW'(shadow));
    rd(A_CMD, rv);  chk("R1 high cmd bits", rv, DW'(shadow));
    rd(A_STAT, rv); chk("R1 no start on high bits", rv, 0);
    wr(dadr(4), 32'h0);
    rd(dadr(4), rv); chk("R1 data read-only", rv, 32'h14AF);
    rd(AW'(5), rv);  chk("R1 unmapped", rv, 0);

    // R9 reset mid-run
    rst_n = 0; cyc(1); rst_n = 1; cyc(1);
    rd(A_CMD, rv);   chk("R9 cmd cleared", rv, 0);
    rd(dadr(4), rv); chk("R9 data cleared", rv, 0);
    rd(dadr(15), rv); chk("R9 ch15 cleared", rv, 0);

    fin = 1;
    $display("  Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule